// File: doc/BRIEF.md
# Single-Digit Flashing Frequency Readout

This block lets one seven-segment digit report a three-digit frequency figure. It flashes three decimal digits in turn, with a short dark gap between them and a long dark pause after the last one. The sequence then repeats. The tuning step size that is currently selected decides which three digits appear. Coarse steps show the MHz tens, the MHz units and the 100 kHz digit. Fine steps show the kHz hundreds, tens and units. All durations are counted in pulses of an external timebase strobe. With the defaults, one strobe is meant as 0.1 s: a digit lasts 0.2 s, a gap 0.1 s and the pause 2 s.

While the step-size button is held, the digit shows the step index instead. A display-enable switch blanks everything. Releasing a tuning (up or down) button during the long pause starts a new sequence at once, so the new figure appears as soon as tuning stops. At the start of each sequence the block captures the frequency digits and the step size. A change made while a sequence is running therefore only shows in the next sequence.

The controller is a five-state machine:
- ST_OFF: disabled or just reset.
- ST_SPEED: showing the step index.
- ST_DIGIT: one digit lit.
- ST_GAP: dark between digits.
- ST_PAUSE: long dark interval.

The transitions are:
- Enable low forces ST_OFF from any state.
- The held step button forces ST_SPEED from any state while enabled.
- ST_OFF and ST_SPEED go to ST_DIGIT (the sequence start) as soon as neither override applies.
- ST_DIGIT goes to ST_GAP on the lit-time expiry for the first and second digits, and to ST_PAUSE for the third.
- ST_GAP goes to ST_DIGIT (the next digit) on the gap expiry.
- ST_PAUSE goes to ST_DIGIT (the sequence start) on the pause expiry or on a tuning-button release.

Top module: `flash_digit_seq`

## Requirements
- R1: While reset is asserted and in the first sampled cycle of reset, `blank` is 1 and `seg` is all zeros.
- R2: `seg` is active-high with bit 0 = segment a through bit 6 = segment g. Digits 0..9 use the hex patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. A digit code of 10..15 lights no segment.
- R3: `freq_bcd` packs five BCD digits: [19:16] MHz tens, [15:12] MHz units, [11:8] kHz hundreds (the 100 kHz digit), [7:4] kHz tens, [3:0] kHz units. For `speed_idx` 0..3 the sequence shows kHz hundreds, then kHz tens, then kHz units.
- R4: For `speed_idx` 4 or 5 the sequence shows MHz tens, then MHz units, then kHz hundreds.
- R5: A sequence starts on the clock edge that enters ST_DIGIT. Each digit stays lit for ON_TICKS strobes, each gap is dark for GAP_TICKS strobes, and after the third digit the output is dark for PAUSE_TICKS strobes before the first digit shows again.
- R6: A falling edge of (btn_up OR btn_down) during ST_PAUSE restarts the sequence on the next clock edge, including when it coincides with the pause expiry (one restart with a full lit time). A release during a digit or gap changes nothing.
- R7: While `btn_speed` is high and the display is enabled, the digit steadily shows the live `speed_idx` and ignores strobes. On release a new sequence starts on the next edge.
- R8: When `disp_en` is low, `blank` is 1 and `seg` is zero from the next edge on, overriding the step button. Re-enabling starts a new sequence on the next edge.
- R9: The frequency digits and the step size are captured at each sequence start. Changes during a running sequence affect only the following sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe |
| disp_en | input | 1 | Display enable switch |
| btn_up | input | 1 | Tune-up button, high while pressed |
| btn_down | input | 1 | Tune-down button, high while pressed |
| btn_speed | input | 1 | Step-size button, high while pressed |
| speed_idx | input | 3 | Selected step index 0..5 |
| freq_bcd | input | 20 | Five packed BCD frequency digits |
| seg | output | 7 | Segment drive, bit 0 = a .. bit 6 = g |
| blank | output | 1 | High when the digit is dark |

## Verification
Two restart sources can land on the same clock edge: the pause timer expiring and a tuning-button release. The bench counts the pause down to its last strobe. It then drops the button in exactly the cycle that carries the final strobe. The result is judged correct only if the first digit appears on the next edge and stays lit for a full ON_TICKS strobes before the gap. A separate case releases a button in the middle of the second digit and expects the sequence to carry on undisturbed.

// File: rtl/fds_pkg.sv
package fds_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SPEED,
        ST_DIGIT,
        ST_GAP,
        ST_PAUSE
    } seq_state_e;

    localparam int BCD_W = 4;
    localparam int SEG_W = 7;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

endpackage

// File: rtl/fds_seg_encoder.sv
module fds_seg_encoder
    import fds_pkg::*;
(
    input  logic en,
    input  bcd_t value,
    output seg_t seg
);

    function automatic seg_t glyph(input bcd_t v);
        seg_t g;
        unique case (v)
            4'd0:    g = 7'h3F;
            4'd1:    g = 7'h06;
            4'd2:    g = 7'h5B;
            4'd3:    g = 7'h4F;
            4'd4:    g = 7'h66;
            4'd5:    g = 7'h6D;
            4'd6:    g = 7'h7D;
            4'd7:    g = 7'h07;
            4'd8:    g = 7'h7F;
            4'd9:    g = 7'h6F;
            default: g = '0;
        endcase
        return g;
    endfunction

    always_comb begin
        seg = en ? glyph(value) : '0;
    end

endmodule

// File: rtl/fds_digit_pick.sv
module fds_digit_pick
    import fds_pkg::*;
#(
    parameter int NDIG  = 5,
    parameter int IDX_W = 2
) (
    input  logic [NDIG*BCD_W-1:0] word,
    input  logic                  coarse,
    input  logic [IDX_W-1:0]      idx,
    output bcd_t                  digit
);

    localparam int COARSE_TOP = NDIG - 1;
    localparam int FINE_TOP   = NDIG - 3;
    localparam int POS_W      = $clog2(NDIG + 1);

    bcd_t             lane [NDIG];
    logic [POS_W-1:0] pos;

    for (genvar g = 0; g < NDIG; g++) begin : g_lane
        assign lane[g] = word[g*BCD_W +: BCD_W];
    end

    always_comb begin
        pos = coarse ? POS_W'(COARSE_TOP) : POS_W'(FINE_TOP);
        pos = pos - POS_W'(idx);
        digit = '0;
        for (int k = 0; k < NDIG; k++) begin
            if (pos == POS_W'(k)) digit = lane[k];
        end
    end

endmodule

// File: rtl/fds_tick_timer.sv
module fds_tick_timer
    import fds_pkg::*;
#(
    parameter int ON_TICKS    = 2,
    parameter int GAP_TICKS   = 1,
    parameter int PAUSE_TICKS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e phase,
    input  logic       clear,
    input  logic       tick,
    output logic       expire
);

    localparam int MAXT = (PAUSE_TICKS > ON_TICKS) ?
                          ((PAUSE_TICKS > GAP_TICKS) ? PAUSE_TICKS : GAP_TICKS) :
                          ((ON_TICKS > GAP_TICKS) ? ON_TICKS : GAP_TICKS);
    localparam int CW = $clog2(MAXT + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        unique case (phase)
            ST_DIGIT: limit = CW'(ON_TICKS);
            ST_GAP:   limit = CW'(GAP_TICKS);
            ST_PAUSE: limit = CW'(PAUSE_TICKS);
            default:  limit = CW'(MAXT);
        endcase
        expire = tick && (cnt == limit - CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expire ? '0 : cnt + CW'(1);
        end
    end

    // interval count never passes the active limit (R5)
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase inside {ST_DIGIT, ST_GAP, ST_PAUSE}) |-> (cnt < limit));

endmodule

// File: rtl/flash_digit_seq.sv
module flash_digit_seq
    import fds_pkg::*;
#(
    parameter int ON_TICKS    = 2,
    parameter int GAP_TICKS   = 1,
    parameter int PAUSE_TICKS = 20,
    parameter int NDIG        = 5,
    parameter int SPEED_W     = 3,
    parameter int COARSE_MIN  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    disp_en,
    input  logic                    btn_up,
    input  logic                    btn_down,
    input  logic                    btn_speed,
    input  logic [SPEED_W-1:0]      speed_idx,
    input  logic [NDIG*BCD_W-1:0]   freq_bcd,
    output logic [SEG_W-1:0]        seg,
    output logic                    blank
);

    localparam int NSHOW    = 3;
    localparam int IDX_W    = $clog2(NSHOW);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSHOW - 1);

    seq_state_e               st, nxt;
    logic [IDX_W-1:0]         idx, idx_nxt;
    logic [NDIG*BCD_W-1:0]    lat_freq;
    logic                     lat_coarse;
    logic                     tune_prev;
    logic                     tune_now;
    logic                     release_ev;
    logic                     start;
    logic                     expire;
    logic                     tmr_clear;
    bcd_t                     pick;
    bcd_t                     show_val;
    logic                     show_on;

    assign tune_now   = btn_up | btn_down;
    assign release_ev = tune_prev & ~tune_now;

    // next-state logic
    always_comb begin
        nxt     = st;
        idx_nxt = idx;
        start   = 1'b0;
        if (!disp_en) begin
            nxt = ST_OFF;
        end else if (btn_speed) begin
            nxt = ST_SPEED;
        end else begin
            unique case (st)
                ST_OFF, ST_SPEED: start = 1'b1;
                ST_DIGIT: begin
                    if (expire) nxt = (idx == LAST_IDX) ? ST_PAUSE : ST_GAP;
                end
                ST_GAP: begin
                    if (expire) begin
                        nxt     = ST_DIGIT;
                        idx_nxt = idx + IDX_W'(1);
                    end
                end
                ST_PAUSE: begin
                    if (expire || release_ev) start = 1'b1;
                end
                default: nxt = ST_OFF;
            endcase
        end
        if (start) begin
            nxt     = ST_DIGIT;
            idx_nxt = '0;
        end
    end

    assign tmr_clear = start || (nxt != st);

    // state register and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= ST_OFF;
            idx        <= '0;
            lat_freq   <= '0;
            lat_coarse <= 1'b0;
            tune_prev  <= 1'b0;
        end else begin
            st        <= nxt;
            idx       <= idx_nxt;
            tune_prev <= tune_now;
            if (start) begin
                lat_freq   <= freq_bcd;
                lat_coarse <= (speed_idx >= SPEED_W'(COARSE_MIN));
            end
        end
    end

    fds_tick_timer #(
        .ON_TICKS    (ON_TICKS),
        .GAP_TICKS   (GAP_TICKS),
        .PAUSE_TICKS (PAUSE_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (st),
        .clear  (tmr_clear),
        .tick   (tick),
        .expire (expire)
    );

    fds_digit_pick #(
        .NDIG  (NDIG),
        .IDX_W (IDX_W)
    ) u_pick (
        .word   (lat_freq),
        .coarse (lat_coarse),
        .idx    (idx),
        .digit  (pick)
    );

    // output selection
    always_comb begin
        show_val = '0;
        show_on  = 1'b0;
        unique case (st)
            ST_DIGIT: begin
                show_val = pick;
                show_on  = 1'b1;
            end
            ST_SPEED: begin
                show_val = BCD_W'(speed_idx);
                show_on  = 1'b1;
            end
            default: begin
                show_val = '0;
                show_on  = 1'b0;
            end
        endcase
        blank = ~show_on;
    end

    fds_seg_encoder u_enc (
        .en    (show_on),
        .value (show_val),
        .seg   (seg)
    );

    p_off_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> (blank && seg == '0));

    p_speed_show_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && btn_speed) |=> (!blank && st == ST_SPEED));

    p_release_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAUSE && disp_en && !btn_speed && release_ev)
        |=> (st == ST_DIGIT && idx == '0));

    p_capture_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && !btn_speed && !start && st inside {ST_DIGIT, ST_GAP, ST_PAUSE})
        |=> ($stable(lat_freq) && $stable(lat_coarse)));

    p_gap_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP && expire && disp_en && !btn_speed)
        |=> (st == ST_DIGIT && idx == IDX_W'($past(idx) + IDX_W'(1))));

    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);

endmodule

// File: tb/flash_digit_seq_tb_top.sv
module flash_digit_seq_tb_top;

    localparam int ON_T    = 2;
    localparam int GAP_T   = 1;
    localparam int PAUSE_T = 20;
    localparam logic [7:0] DARK = 8'h80;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        disp_en;
    logic        btn_up;
    logic        btn_down;
    logic        btn_speed;
    logic [2:0]  speed_idx;
    logic [19:0] freq_bcd;
    logic [6:0]  seg;
    logic        blank;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flash_digit_seq #(
        .ON_TICKS    (ON_T),
        .GAP_TICKS   (GAP_T),
        .PAUSE_TICKS (PAUSE_T)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .disp_en   (disp_en),
        .btn_up    (btn_up),
        .btn_down  (btn_down),
        .btn_speed (btn_speed),
        .speed_idx (speed_idx),
        .freq_bcd  (freq_bcd),
        .seg       (seg),
        .blank     (blank)
    );

    function automatic logic [6:0] ref_seg(input int d);
        case (d)
            0: return 7'h3F;
            1: return 7'h06;
            2: return 7'h5B;
            3: return 7'h4F;
            4: return 7'h66;
            5: return 7'h6D;
            6: return 7'h7D;
            7: return 7'h07;
            8: return 7'h7F;
            9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [7:0] lit(input int d);
        return {1'b0, ref_seg(d)};
    endfunction

    function automatic logic [19:0] fq(input int a, input int b, input int c,
                                       input int d, input int e);
        return {4'(a), 4'(b), 4'(c), 4'(d), 4'(e)};
    endfunction

    task automatic chk(input string req, input logic [7:0] exp);
        n_chk++;
        if ({blank, seg} !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, {blank, seg}, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) pulse_tick();
    endtask

    task automatic restart();
        disp_en = 1'b0;
        cyc();
        chk("R8 disabled", DARK);
        disp_en = 1'b1;
        cyc();
    endtask

    // walks one full sequence plus pause, ends with first digit shown again
    task automatic walk(input int d0, input int d1, input int d2, input string req);
        int ds [3];
        ds[0] = d0; ds[1] = d1; ds[2] = d2;
        for (int i = 0; i < 3; i++) begin
            chk(req, lit(ds[i]));
            for (int k = 1; k < ON_T; k++) begin
                pulse_tick();
                chk({req, " R5 lit"}, lit(ds[i]));
            end
            pulse_tick();
            chk({req, " R5 dark"}, DARK);
            if (i < 2) begin
                for (int k = 1; k < GAP_T; k++) begin
                    pulse_tick();
                    chk({req, " R5 gap"}, DARK);
                end
                pulse_tick();
            end
        end
        ticks(PAUSE_T - 1);
        chk({req, " R5 pause"}, DARK);
        pulse_tick();
        chk({req, " R5 repeat"}, lit(d0));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick = 1'b0; disp_en = 1'b1;
        btn_up = 1'b0; btn_down = 1'b0; btn_speed = 1'b0;
        speed_idx = 3'd2; freq_bcd = fq(2, 1, 3, 4, 5);
        #1;
        chk("R1 first", DARK);
        cyc(3);
        chk("R1 held", DARK);
    endtask

    task automatic t_fine();
        rst_n = 1'b1;
        cyc();
        walk(3, 4, 5, "R3 fine");
    endtask

    task automatic t_coarse();
        speed_idx = 3'd5;
        restart();
        walk(2, 1, 3, "R4 coarse");
        speed_idx = 3'd4;
        restart();
        chk("R4 idx4", lit(2));
    endtask

    task automatic t_encode();
        speed_idx = 3'd0;
        for (int d = 0; d < 10; d++) begin
            freq_bcd = fq(0, 0, d, 0, 0);
            restart();
            chk("R2 glyph", lit(d));
        end
        freq_bcd = {8'h00, 4'hC, 8'h00};
        restart();
        chk("R2 invalid code", 8'h00);
    endtask

    task automatic t_release();
        speed_idx = 3'd2;
        freq_bcd  = fq(2, 1, 3, 4, 5);
        restart();
        ticks(3 * ON_T + 2 * GAP_T);
        ticks(5);
        chk("R6 in pause", DARK);
        btn_up = 1'b1;
        cyc();
        chk("R6 press no effect", DARK);
        btn_up = 1'b0;
        cyc();
        chk("R6 release restarts", lit(3));
        ticks(ON_T + GAP_T);
        chk("R6 second digit", lit(4));
        btn_down = 1'b1;
        cyc();
        btn_down = 1'b0;
        cyc();
        chk("R6 release mid digit ignored", lit(4));
        pulse_tick();
        chk("R6 continues", lit(4));
    endtask

    task automatic t_coincide();
        restart();
        ticks(3 * ON_T + 2 * GAP_T);
        ticks(PAUSE_T - 1);
        chk("R6 pause end", DARK);
        btn_up = 1'b1;
        cyc();
        btn_up = 1'b0;
        tick   = 1'b1;
        cyc();
        tick   = 1'b0;
        chk("R6 coincident restart", lit(3));
        for (int k = 1; k < ON_T; k++) begin
            pulse_tick();
            chk("R6 R5 full lit time", lit(3));
        end
        pulse_tick();
        chk("R6 R5 gap after", DARK);
    endtask

    task automatic t_speed();
        speed_idx = 3'd3;
        btn_speed = 1'b1;
        cyc();
        chk("R7 speed shown", lit(3));
        ticks(25);
        chk("R7 steady", lit(3));
        disp_en = 1'b0;
        cyc();
        chk("R8 overrides speed", DARK);
        disp_en = 1'b1;
        cyc();
        chk("R7 after enable", lit(3));
        speed_idx = 3'd4;
        cyc();
        chk("R7 live index", lit(4));
        btn_speed = 1'b0;
        cyc();
        chk("R7 release restarts", lit(2));
    endtask

    task automatic t_latch();
        speed_idx = 3'd2;
        freq_bcd  = fq(2, 1, 3, 4, 5);
        restart();
        chk("R9 start", lit(3));
        freq_bcd  = fq(0, 7, 8, 9, 0);
        speed_idx = 3'd5;
        ticks(ON_T + GAP_T);
        chk("R9 old second", lit(4));
        ticks(ON_T + GAP_T);
        chk("R9 old third", lit(5));
        ticks(ON_T + PAUSE_T);
        chk("R9 new first", lit(0));
        ticks(ON_T + GAP_T);
        chk("R9 new second", lit(7));
        ticks(ON_T + GAP_T);
        chk("R9 new third", lit(8));
    endtask

    initial begin
        t_reset();
        t_fine();
        t_coarse();
        t_encode();
        t_release();
        t_coincide();
        t_speed();
        t_latch();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule